// File: doc/BRIEF.md
# PS/2 Host Transceiver

This block is the host end of a two-wire PS/2 link. It runs on the system clock and watches the device's clock and data lines through a synchronizer. It drives either line only through an active-high pull-low enable, so each line is open-drain with a pull-up. Device-to-host frames are collected on detected falling edges of the device clock. The received byte comes out with a one-cycle ready strobe and an error flag. The flag covers a bad start bit, bad odd parity or a bad stop bit, and the byte is delivered even when the flag is set.

To send, the host logic raises `send_req` for one cycle with the byte on `tx_byte`. The block holds the clock line low for `INHIBIT_CYCLES` cycles with data also pulled low, then releases the clock and keeps data low as the start bit. From then on the device clocks the frame: after each device falling edge the next frame bit is placed on the data line, ready for the device to read on the following rising edge. `busy` covers the whole sequence and drops after the rising edge of the eleventh device pulse.

Two state machines do the work. The receiver has `RX_IDLE` and `RX_SHIFT`. It moves from `RX_IDLE` to `RX_SHIFT` on a detected falling edge when no transmit claims the link. It returns to `RX_IDLE` on the eleventh edge, or at once when a transmit claims the link. The transmitter has `TX_IDLE`, `TX_INHIB` and `TX_RUN`. It moves from `TX_IDLE` to `TX_INHIB` on `send_req`, and from `TX_INHIB` to `TX_RUN` when the inhibit counter expires. It moves from `TX_RUN` to `TX_IDLE` on the first detected rising edge after eleven falling edges. `INHIBIT_CYCLES` must exceed `SYNC_STAGES + 1`, so that the edge caused by the host's own clock pull has passed before edges are counted.

Top module: `ps2_host_xcvr`

## Requirements
- R1: Synchronous reset clears `busy`, `rx_ready`, `rx_err`, `rx_byte` and both pull-low enables, and discards any partly received frame, so that the next complete frame is received correctly.
- R2: A received frame is 11 bits, each sampled on a detected falling edge of the device clock, in this order: start, data bit 0 through data bit 7, parity, stop. `rx_byte` presents the eight data bits with the first data bit in bit 0.
- R3: `rx_ready` is high for exactly one cycle. That cycle is the one after the third system clock rising edge following the moment the device clock line falls for the eleventh time (two synchronizer stages plus one register).
- R4: `rx_err` is set with `rx_ready` when the start bit is 1, or the stop bit is 0, or the data bits and parity bit together hold an even number of ones. `rx_byte` still carries the data bits in that case.
- R5: Frames are received correctly when the device clock spends only two system cycles in each half-period.
- R6: A `send_req` while idle raises `busy` on the next cycle. It raises `ps2_clk_oe` for exactly `INHIBIT_CYCLES` cycles from that cycle, and during those cycles `ps2_dat_oe` is also high.
- R7: After the clock line is released, data stays low (start bit) until the first device falling edge. After falling edge k the data line carries data bit k-1 for k = 1..8, odd parity for k = 9, and released high for k = 10 and 11.
- R8: `busy` falls on the third system clock rising edge after the device clock line rises for the eleventh time during a transmit. Both pull-low enables are low whenever `busy` is low.
- R9: A `send_req` while `busy` is high is ignored: the frame, the inhibit and the `busy` timing are unchanged.
- R10: Device clock edges while `busy` is high never produce `rx_ready`, and reception works normally once `busy` is low.
- R11: `rx_byte` and `rx_err` keep their values between `rx_ready` strobes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ps2_clk_i | input | 1 | Device clock line as seen at the pad |
| ps2_dat_i | input | 1 | Data line as seen at the pad |
| ps2_clk_oe | output | 1 | Pulls the clock line low when high |
| ps2_dat_oe | output | 1 | Pulls the data line low when high |
| send_req | input | 1 | One-cycle request to transmit `tx_byte` |
| tx_byte | input | 8 | Byte to transmit, taken with `send_req` |
| busy | output | 1 | Transmit sequence in progress |
| rx_byte | output | 8 | Last received data byte |
| rx_ready | output | 1 | One-cycle strobe: frame received |
| rx_err | output | 1 | Start, parity or stop violation in last frame |

## Verification
The bench builds the block with `SYNC_STAGES = 2` and `INHIBIT_CYCLES = 6`. Two stages fix the edge-to-output latency at three cycles, which lets the reference model predict `rx_ready` and the fall of `busy` to the exact cycle. It also makes a device half-period of two system cycles the fastest receivable rate, so that rate is exercised directly. The short inhibit keeps each transmit near 150 cycles, leaving room for extreme and mixed byte values, every class of receive error, a request issued in the middle of a transmit, and a reset that cuts a frame in half.

// File: rtl/ps2x_pkg.sv
package ps2x_pkg;
    localparam int DATA_BITS  = 8;
    localparam int FRAME_BITS = DATA_BITS + 3;
    localparam int CNT_W      = $clog2(FRAME_BITS + 1);

    typedef enum logic [0:0] {
        RX_IDLE  = 1'b0,
        RX_SHIFT = 1'b1
    } rx_state_e;

    typedef enum logic [1:0] {
        TX_IDLE  = 2'd0,
        TX_INHIB = 2'd1,
        TX_RUN   = 2'd2
    } tx_state_e;
endpackage

// File: rtl/ps2x_sync.sv
module ps2x_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] line_i,
    output logic [WIDTH-1:0] line_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        logic [WIDTH-1:0] src;
        if (s == 0) begin : g_first
            assign src = line_i;
        end else begin : g_next
            assign src = stage_q[s-1];
        end
        always_ff @(posedge clk) begin
            if (rst) stage_q[s] <= '1;
            else     stage_q[s] <= src;
        end
    end

    assign line_o = stage_q[STAGES-1];
endmodule

// File: rtl/ps2x_edge.sv
module ps2x_edge (
    input  logic clk,
    input  logic rst,
    input  logic level,
    output logic fall,
    output logic rise
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b1;
        else     prev_q <= level;
    end

    assign fall = prev_q & ~level;
    assign rise = ~prev_q & level;
endmodule

// File: rtl/ps2x_rx.sv
module ps2x_rx
    import ps2x_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 fall,
    input  logic                 dat,
    input  logic                 claim,
    output logic [DATA_BITS-1:0] rx_byte,
    output logic                 rx_ready,
    output logic                 rx_err
);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_BITS - 1);

    rx_state_e             state_q, state_d;
    logic [FRAME_BITS-1:0] sh_q;
    logic [FRAME_BITS-1:0] sh_next;
    logic [CNT_W-1:0]      cnt_q;
    logic                  last_bit;

    assign sh_next  = {dat, sh_q[FRAME_BITS-1:1]};
    assign last_bit = (state_q == RX_SHIFT) && fall && (cnt_q == LAST_IDX);

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= RX_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_IDLE:  if (fall && !claim) state_d = RX_SHIFT;
            RX_SHIFT: if (claim || last_bit) state_d = RX_IDLE;
        endcase
    end

    // frame assembly and outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q     <= '0;
            cnt_q    <= '0;
            rx_byte  <= '0;
            rx_ready <= 1'b0;
            rx_err   <= 1'b0;
        end else begin
            rx_ready <= 1'b0;
            if (claim) begin
                cnt_q <= '0;
            end else if (fall) begin
                sh_q <= sh_next;
                if (last_bit) begin
                    cnt_q    <= '0;
                    rx_ready <= 1'b1;
                    rx_byte  <= sh_next[DATA_BITS:1];
                    rx_err   <= sh_next[0] | ~sh_next[FRAME_BITS-1]
                              | ~(^sh_next[DATA_BITS+1:1]);
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/ps2x_tx.sv
module ps2x_tx
    import ps2x_pkg::*;
#(
    parameter int INHIBIT_CYCLES = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 send_req,
    input  logic [DATA_BITS-1:0] tx_byte,
    input  logic                 fall,
    input  logic                 rise,
    output logic                 busy,
    output logic                 clk_oe,
    output logic                 dat_oe,
    output logic                 claim
);
    localparam int               INH_W    = $clog2(INHIBIT_CYCLES + 1);
    localparam logic [INH_W-1:0] INH_LOAD = INH_W'(INHIBIT_CYCLES - 1);
    localparam logic [CNT_W-1:0] ALL_BITS = CNT_W'(FRAME_BITS);

    tx_state_e             state_q, state_d;
    logic [FRAME_BITS-1:0] sh_q;
    logic [CNT_W-1:0]      cnt_q;
    logic [INH_W-1:0]      inh_q;
    logic                  dat_oe_q;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= TX_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE:  if (send_req) state_d = TX_INHIB;
            TX_INHIB: if (inh_q == '0) state_d = TX_RUN;
            TX_RUN:   if (rise && cnt_q == ALL_BITS) state_d = TX_IDLE;
            default:  state_d = TX_IDLE;
        endcase
    end

    // frame shifter, inhibit timer, data pull
    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q     <= '1;
            cnt_q    <= '0;
            inh_q    <= '0;
            dat_oe_q <= 1'b0;
        end else begin
            unique case (state_q)
                TX_IDLE: begin
                    if (send_req) begin
                        sh_q     <= {1'b1, ~^tx_byte, tx_byte, 1'b0};
                        cnt_q    <= '0;
                        inh_q    <= INH_LOAD;
                        dat_oe_q <= 1'b1;
                    end
                end
                TX_INHIB: begin
                    inh_q <= inh_q - 1'b1;
                end
                TX_RUN: begin
                    if (fall && cnt_q != ALL_BITS) begin
                        sh_q     <= {1'b1, sh_q[FRAME_BITS-1:1]};
                        dat_oe_q <= ~sh_q[1];
                        cnt_q    <= cnt_q + 1'b1;
                    end else if (rise && cnt_q == ALL_BITS) begin
                        dat_oe_q <= 1'b0;
                    end
                end
                default: dat_oe_q <= 1'b0;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy   = (state_q != TX_IDLE);
        clk_oe = (state_q == TX_INHIB);
        dat_oe = dat_oe_q;
        claim  = busy | send_req;
    end
endmodule

// File: rtl/ps2_host_xcvr.sv
module ps2_host_xcvr
    import ps2x_pkg::*;
#(
    parameter int SYNC_STAGES    = 2,
    parameter int INHIBIT_CYCLES = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ps2_clk_i,
    input  logic                 ps2_dat_i,
    output logic                 ps2_clk_oe,
    output logic                 ps2_dat_oe,
    input  logic                 send_req,
    input  logic [DATA_BITS-1:0] tx_byte,
    output logic                 busy,
    output logic [DATA_BITS-1:0] rx_byte,
    output logic                 rx_ready,
    output logic                 rx_err
);
    logic [1:0] line_s;
    logic       clk_fall, clk_rise, claim;

    ps2x_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .line_i ({ps2_dat_i, ps2_clk_i}),
        .line_o (line_s)
    );

    ps2x_edge u_edge (
        .clk   (clk),
        .rst   (rst),
        .level (line_s[0]),
        .fall  (clk_fall),
        .rise  (clk_rise)
    );

    ps2x_rx u_rx (
        .clk      (clk),
        .rst      (rst),
        .fall     (clk_fall),
        .dat      (line_s[1]),
        .claim    (claim),
        .rx_byte  (rx_byte),
        .rx_ready (rx_ready),
        .rx_err   (rx_err)
    );

    ps2x_tx #(.INHIBIT_CYCLES(INHIBIT_CYCLES)) u_tx (
        .clk      (clk),
        .rst      (rst),
        .send_req (send_req),
        .tx_byte  (tx_byte),
        .fall     (clk_fall),
        .rise     (clk_rise),
        .busy     (busy),
        .clk_oe   (ps2_clk_oe),
        .dat_oe   (ps2_dat_oe),
        .claim    (claim)
    );
endmodule

// File: rtl/ps2_host_xcvr_chk.sv
module ps2_host_xcvr_chk (
    input logic       clk,
    input logic       rst,
    input logic       send_req,
    input logic       busy,
    input logic       ps2_clk_oe,
    input logic       ps2_dat_oe,
    input logic       rx_ready,
    input logic [7:0] rx_byte,
    input logic       rx_err
);
    a_r6_inhibit_pulls_data: assert property (@(posedge clk) disable iff (rst)
        ps2_clk_oe |-> ps2_dat_oe);

    a_r6_busy_from_req: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(send_req));

    a_r8_released_when_idle: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!ps2_clk_oe && !ps2_dat_oe));

    a_r9_inhibit_only_at_start: assert property (@(posedge clk) disable iff (rst)
        $rose(ps2_clk_oe) |-> $rose(busy));

    a_r10_no_ready_while_busy: assert property (@(posedge clk) disable iff (rst)
        busy |-> !rx_ready);

    a_r3_ready_single: assert property (@(posedge clk) disable iff (rst)
        rx_ready |=> !rx_ready);

    a_r11_result_held: assert property (@(posedge clk) disable iff (rst)
        !rx_ready |-> ($stable(rx_byte) && $stable(rx_err)));
endmodule

bind ps2_host_xcvr ps2_host_xcvr_chk u_chk (.*);

// File: tb/tb_ps2_host_xcvr.sv
`timescale 1ns/1ps
module tb_ps2_host_xcvr;
    localparam int SYNC = 2;
    localparam int INH  = 6;
    localparam int LAT  = SYNC + 1;
    localparam int HALF = 6;
    localparam int FAST = 2;
    localparam int BIG  = 1 << 30;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       dev_clk = 1'b1;
    logic       dev_dat = 1'b1;
    logic       send_req = 1'b0;
    logic [7:0] tx_byte = 8'h00;
    logic       ps2_clk_oe, ps2_dat_oe, busy, rx_ready, rx_err;
    logic [7:0] rx_byte;

    wire line_clk = dev_clk & ~ps2_clk_oe;
    wire line_dat = dev_dat & ~ps2_dat_oe;

    always #4 clk = ~clk;

    ps2_host_xcvr #(.SYNC_STAGES(SYNC), .INHIBIT_CYCLES(INH)) dut (
        .clk(clk), .rst(rst),
        .ps2_clk_i(line_clk), .ps2_dat_i(line_dat),
        .ps2_clk_oe(ps2_clk_oe), .ps2_dat_oe(ps2_dat_oe),
        .send_req(send_req), .tx_byte(tx_byte),
        .busy(busy), .rx_byte(rx_byte), .rx_ready(rx_ready), .rx_err(rx_err)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    // reference model state
    int         rdy_due = -1;
    logic [7:0] exp_byte = 8'h00;
    logic       exp_err  = 1'b0;
    logic [7:0] hold_byte = 8'h00;
    logic       hold_err  = 1'b0;
    int         b_start = BIG;
    int         b_end   = BIG;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input int got, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s got=%0h exp=%0h (cycle %0d)", req, what, got, exp, cyc);
        end
    endtask

    // cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        #1;
        if (!rst && !done) begin
            automatic bit eb = (cyc >= b_start) && (cyc < b_end);
            automatic bit ec = (cyc >= b_start) && (cyc < b_start + INH);
            chk(busy == eb, "R6/R8", "busy", busy, eb);
            chk(ps2_clk_oe == ec, "R6", "clk_oe", ps2_clk_oe, ec);
            if (cyc == rdy_due) begin
                chk(rx_ready == 1'b1, "R3", "rx_ready", rx_ready, 1);
                chk(rx_byte == exp_byte, "R2", "rx_byte", rx_byte, exp_byte);
                chk(rx_err == exp_err, "R4", "rx_err", rx_err, exp_err);
                hold_byte = exp_byte;
                hold_err  = exp_err;
            end else begin
                chk(rx_ready == 1'b0, "R3/R10", "rx_ready", rx_ready, 0);
                chk(rx_byte == hold_byte, "R11", "rx_byte held", rx_byte, hold_byte);
                chk(rx_err == hold_err, "R11", "rx_err held", rx_err, hold_err);
            end
        end
    end

    // device sends nbits of a frame to the host
    task automatic dev_frame(input bit st, input logic [7:0] b, input bit par,
                             input bit sp, input int half, input int nbits);
        logic [10:0] fr = {sp, par, b, st};
        for (int k = 0; k < nbits; k++) begin
            dev_dat = fr[k];
            repeat (half) @(negedge clk);
            dev_clk = 1'b0;
            if (k == 10) begin
                rdy_due  = cyc + LAT;
                exp_byte = b;
                exp_err  = st | ~sp | (par != ~^b);
            end
            repeat (half) @(negedge clk);
            dev_clk = 1'b1;
        end
        dev_dat = 1'b1;
        repeat (half + 4) @(negedge clk);
    endtask

    // host sends a byte; device clocks it and reads each bit on its rising edge
    task automatic host_send(input logic [7:0] b, input bit poke);
        @(negedge clk);
        tx_byte  = b;
        send_req = 1'b1;
        b_start  = cyc + 1;
        b_end    = BIG;
        @(negedge clk);
        send_req = 1'b0;
        tx_byte  = ~b;
        while (cyc < b_start + INH + LAT + 2) @(negedge clk);
        chk(line_dat == 1'b0, "R7", "start bit", line_dat, 0);
        for (int k = 1; k <= 11; k++) begin
            automatic logic expb = (k <= 8) ? b[k-1] : (k == 9) ? ~^b : 1'b1;
            dev_clk = 1'b0;
            repeat (HALF) @(negedge clk);
            chk(line_dat == expb, poke ? "R9" : "R7", "tx bit", line_dat, expb);
            dev_clk = 1'b1;
            if (k == 11) b_end = cyc + LAT;
            if (poke && k == 4) begin
                @(negedge clk);
                send_req = 1'b1;
                @(negedge clk);
                send_req = 1'b0;
                repeat (HALF - 2) @(negedge clk);
            end else begin
                repeat (HALF) @(negedge clk);
            end
        end
        repeat (LAT + 2) @(negedge clk);
        chk(busy == 1'b0, "R8", "busy after frame", busy, 0);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        #1;
        chk(busy == 0 && ps2_clk_oe == 0 && ps2_dat_oe == 0, "R1", "tx outputs in reset",
            {busy, ps2_clk_oe, ps2_dat_oe}, 0);
        chk(rx_ready == 0 && rx_err == 0 && rx_byte == 0, "R1", "rx outputs in reset",
            {rx_ready, rx_err, rx_byte}, 0);
        @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);

        // R2/R4: clean frames with varied bytes
        dev_frame(1'b0, 8'h00, 1'b1, 1'b1, HALF, 11);
        dev_frame(1'b0, 8'hFF, 1'b1, 1'b1, HALF, 11);
        for (int i = 0; i < 6; i++) begin
            automatic logic [7:0] v = 8'(i * 53 + 17);
            dev_frame(1'b0, v, ~^v, 1'b1, HALF, 11);
        end
        // R4: each error class, byte still delivered
        dev_frame(1'b1, 8'h5A, ~^8'h5A, 1'b1, HALF, 11);
        dev_frame(1'b0, 8'h5A, ^8'h5A, 1'b1, HALF, 11);
        dev_frame(1'b0, 8'hC3, ~^8'hC3, 1'b0, HALF, 11);
        dev_frame(1'b1, 8'h81, ^8'h81, 1'b0, HALF, 11);
        // R5: fastest device clock
        for (int i = 0; i < 4; i++) begin
            automatic logic [7:0] v = 8'(i * 91 + 3);
            dev_frame(1'b0, v, ~^v, 1'b1, FAST, 11);
        end
        dev_frame(1'b0, 8'h7E, ^8'h7E, 1'b1, FAST, 11);

        // R6/R7/R8: transmit
        host_send(8'h00, 1'b0);
        host_send(8'hFF, 1'b0);
        host_send(8'hA5, 1'b0);
        // R9: request while busy
        host_send(8'h3C, 1'b1);
        // R10: reception after a transmit
        dev_frame(1'b0, 8'h96, ~^8'h96, 1'b1, HALF, 11);

        // R1: reset in the middle of a frame
        dev_frame(1'b0, 8'hFF, 1'b1, 1'b1, HALF, 5);
        @(negedge clk);
        rst = 1'b1;
        hold_byte = 8'h00;
        hold_err  = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        dev_frame(1'b0, 8'h21, ~^8'h21, 1'b1, HALF, 11);
        #1;
        chk(rx_byte == 8'h21 && rx_err == 1'b0, "R1", "frame after reset",
            {rx_err, rx_byte}, 8'h21);

        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule